// File: doc/BRIEF.md
# Balanced-DAC Sample Negation Splitter

This block takes two's complement audio samples from a left and a right channel. Each channel has its own valid strobe. For one chosen channel it forms a pair of words to drive a differential pair of DAC channels: the sample itself, and its arithmetic opposite. Both words appear in the same cycle, under a single output strobe, so both halves of the balanced DAC can latch at the same moment.

A static mode input picks how the opposite word is formed. In exact mode the word is inverted and incremented. The one code that has no positive counterpart, the most negative code, is saturated to the most positive code. In inversion mode the bits are simply flipped. That result is minus the sample minus one, a constant one-LSB offset with no overflow case. A further input can pull a most-negative sample up by one code before either word is formed, which keeps the pair symmetric. The mode, clamp and channel-select inputs are taken only in the cycle a sample is accepted, so a setting change never splits a pair.

Top module: `bal_negate_splitter`

## Requirements
- R1: While `rst` is high at a rising clock edge, `trueWord` and `compWord` become 0x0000 and `pairValid` becomes 0.
- R2: A sample is accepted in a cycle when the valid strobe of the selected channel is high. `pairValid` is high in the cycle after an accepted sample and low in the cycle after a cycle with no accepted sample. Both words update at that same edge.
- R3: `chanSel`=0 selects the left channel and `chanSel`=1 selects the right channel. A valid strobe on the unselected channel is ignored: no strobe and no change to either word.
- R4: With `exactMode`=1 and the sample not 0x8000, `compWord` equals the bitwise inverse of the sample plus one (mod 2^16), and `trueWord` equals the sample.
- R5: With `exactMode`=1, `clampInput`=0 and sample 0x8000, `trueWord` is 0x8000 and `compWord` is 0x7FFF.
- R6: With `exactMode`=0, `compWord` is the bitwise inverse of `trueWord`. For example, 0x8000 maps to 0x7FFF and 0x0000 maps to 0xFFFF.
- R7: With `clampInput`=1, a sample of 0x8000 is first replaced by 0x8001. `trueWord` is then 0x8001, and `compWord` is 0x7FFF in exact mode or 0x7FFE in inversion mode. Other samples are unaffected.
- R8: `exactMode`, `clampInput` and `chanSel` are used only in a cycle with an accepted sample. Changing them in other cycles leaves both words unchanged.
- R9: Between output strobes, `trueWord` and `compWord` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| leftValid | input | 1 | Left sample strobe |
| leftSample | input | 16 | Left two's complement sample |
| rightValid | input | 1 | Right sample strobe |
| rightSample | input | 16 | Right two's complement sample |
| chanSel | input | 1 | 0 = left, 1 = right |
| exactMode | input | 1 | 1 = invert plus one with saturation, 0 = plain inversion |
| clampInput | input | 1 | 1 = lift 0x8000 input to 0x8001 |
| pairValid | output | 1 | One-cycle strobe: the pair is new |
| trueWord | output | 16 | Sample as received (after optional clamp) |
| compWord | output | 16 | Complemented sample |

## Verification
The hardest case to reach is the most negative code crossed with every combination of mode and input clamp. It is the only place where exact negation would overflow, and the only place the clamp does anything. The bench therefore sends 0x8000 under all four settings of the two inputs and checks each resulting pair. It also changes the mode and channel select between samples, and pulses the unselected channel's strobe, to show that the held pair is left untouched.

// File: rtl/bal_negate_pkg.sv
package bal_negate_pkg;
  typedef struct packed {
    logic load;
    logic pickRight;
    logic useExact;
    logic liftMin;
  } ctrl_t;
endpackage

// File: rtl/bal_negate_ctrl.sv
module bal_negate_ctrl
  import bal_negate_pkg::*;
(
  input  logic  leftValid,
  input  logic  rightValid,
  input  logic  chanSel,
  input  logic  exactMode,
  input  logic  clampInput,
  output ctrl_t ctrl
);
  always_comb begin
    ctrl.pickRight = chanSel;
    ctrl.load      = chanSel ? rightValid : leftValid;
    ctrl.useExact  = exactMode;
    ctrl.liftMin   = clampInput;
  end
endmodule

// File: rtl/bal_negate_dp.sv
module bal_negate_dp
  import bal_negate_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            ctrl,
  input  logic [WIDTH-1:0] leftSample,
  input  logic [WIDTH-1:0] rightSample,
  output logic             pairValid,
  output logic [WIDTH-1:0] trueWord,
  output logic [WIDTH-1:0] compWord
);
  localparam logic [WIDTH-1:0] MIN_CODE = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] MAX_CODE = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] picked, lifted, inverted, nextComp;

  always_comb begin
    picked   = ctrl.pickRight ? rightSample : leftSample;
    lifted   = (ctrl.liftMin && picked == MIN_CODE) ? MIN_CODE + ONE : picked;
    inverted = ~lifted;
    if (!ctrl.useExact)
      nextComp = inverted;
    else if (lifted == MIN_CODE)
      nextComp = MAX_CODE;
    else
      nextComp = inverted + ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pairValid <= 1'b0;
      trueWord  <= '0;
      compWord  <= '0;
    end else begin
      pairValid <= ctrl.load;
      if (ctrl.load) begin
        trueWord <= lifted;
        compWord <= nextComp;
      end
    end
  end
endmodule

// File: rtl/bal_negate_splitter.sv
module bal_negate_splitter
  import bal_negate_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             leftValid,
  input  logic [WIDTH-1:0] leftSample,
  input  logic             rightValid,
  input  logic [WIDTH-1:0] rightSample,
  input  logic             chanSel,
  input  logic             exactMode,
  input  logic             clampInput,
  output logic             pairValid,
  output logic [WIDTH-1:0] trueWord,
  output logic [WIDTH-1:0] compWord
);
  ctrl_t ctrl;

  bal_negate_ctrl u_ctrl (
    .leftValid  (leftValid),
    .rightValid (rightValid),
    .chanSel    (chanSel),
    .exactMode  (exactMode),
    .clampInput (clampInput),
    .ctrl       (ctrl)
  );

  bal_negate_dp #(.WIDTH(WIDTH)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .ctrl        (ctrl),
    .leftSample  (leftSample),
    .rightSample (rightSample),
    .pairValid   (pairValid),
    .trueWord    (trueWord),
    .compWord    (compWord)
  );
endmodule

// File: rtl/bal_negate_checker.sv
module bal_negate_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             leftValid,
  input logic             rightValid,
  input logic             chanSel,
  input logic             exactMode,
  input logic             clampInput,
  input logic             pairValid,
  input logic [WIDTH-1:0] trueWord,
  input logic [WIDTH-1:0] compWord
);
  localparam logic [WIDTH-1:0] MIN_CODE = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] MAX_CODE = {1'b0, {(WIDTH-1){1'b1}}};

  logic armed;
  logic took;
  always_ff @(posedge clk) armed <= !rst;
  assign took = chanSel ? rightValid : leftValid;

  AST_STROBE_TIMING: assert property (@(posedge clk) disable iff (rst)
    armed |-> pairValid == $past(took));                                   // R2
  AST_HOLD_WORDS: assert property (@(posedge clk) disable iff (rst)
    (armed && !took) |=> ($stable(trueWord) && $stable(compWord)));        // R9
  AST_EXACT_SUM: assert property (@(posedge clk) disable iff (rst)
    (pairValid && $past(exactMode) && trueWord != MIN_CODE)
      |-> (WIDTH'(trueWord + compWord) == '0));                            // R4
  AST_MIN_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (pairValid && $past(exactMode) && trueWord == MIN_CODE)
      |-> compWord == MAX_CODE);                                           // R5
  AST_INVERT_PAIR: assert property (@(posedge clk) disable iff (rst)
    (pairValid && !$past(exactMode)) |-> compWord == ~trueWord);           // R6
  AST_LIFT_MIN: assert property (@(posedge clk) disable iff (rst)
    (pairValid && $past(clampInput)) |-> trueWord != MIN_CODE);            // R7
endmodule

bind bal_negate_splitter bal_negate_checker #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .leftValid  (leftValid),
  .rightValid (rightValid),
  .chanSel    (chanSel),
  .exactMode  (exactMode),
  .clampInput (clampInput),
  .pairValid  (pairValid),
  .trueWord   (trueWord),
  .compWord   (compWord)
);

// File: tb/bal_negate_splitter_tb.sv
module bal_negate_splitter_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic leftValid = 1'b0, rightValid = 1'b0;
  logic [15:0] leftSample = '0, rightSample = '0;
  logic chanSel = 1'b0, exactMode = 1'b1, clampInput = 1'b0;
  logic pairValid;
  logic [15:0] trueWord, compWord;
  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  bal_negate_splitter u_dut (
    .clk(clk), .rst(rst),
    .leftValid(leftValid), .leftSample(leftSample),
    .rightValid(rightValid), .rightSample(rightSample),
    .chanSel(chanSel), .exactMode(exactMode), .clampInput(clampInput),
    .pairValid(pairValid), .trueWord(trueWord), .compWord(compWord)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] modelTrue(logic [15:0] s, logic clampOn);
    return (clampOn && s == 16'h8000) ? 16'h8001 : s;
  endfunction

  function automatic logic [15:0] modelComp(logic [15:0] s, logic ex, logic clampOn);
    logic [15:0] t = modelTrue(s, clampOn);
    if (!ex) return ~t;
    if (t == 16'h8000) return 16'h7FFF;
    return 16'(~t + 16'h0001);
  endfunction

  // drive at negedge, capture at posedge, check at the following negedge
  task automatic sendPair(string req, logic ch, logic [15:0] s, logic ex, logic clampOn);
    @(negedge clk);
    chanSel = ch; exactMode = ex; clampInput = clampOn;
    if (ch) begin rightSample = s; rightValid = 1'b1; leftSample = ~s; end
    else    begin leftSample = s;  leftValid = 1'b1;  rightSample = ~s; end
    @(negedge clk);
    leftValid = 1'b0; rightValid = 1'b0;
    check({req, " strobe R2"}, {31'd0, pairValid}, 32'd1);
    check({req, " true"}, {16'd0, trueWord}, {16'd0, modelTrue(s, clampOn)});
    check({req, " comp"}, {16'd0, compWord}, {16'd0, modelComp(s, ex, clampOn)});
    @(negedge clk);
    check({req, " pulse ends R2"}, {31'd0, pairValid}, 32'd0);
  endtask

  task automatic testReset();
    check("R1 strobe", {31'd0, pairValid}, 32'd0);
    check("R1 true", {16'd0, trueWord}, 32'd0);
    check("R1 comp", {16'd0, compWord}, 32'd0);
  endtask

  task automatic testExact();
    sendPair("R4 one", 1'b0, 16'h0001, 1'b1, 1'b0);
    sendPair("R4 mixed", 1'b0, 16'h1234, 1'b1, 1'b0);
    sendPair("R4 max", 1'b1, 16'h7FFF, 1'b1, 1'b0);
    sendPair("R4 minus one", 1'b1, 16'hFFFF, 1'b1, 1'b0);
    sendPair("R4 zero", 1'b0, 16'h0000, 1'b1, 1'b0);
    sendPair("R5 min saturate", 1'b0, 16'h8000, 1'b1, 1'b0);
  endtask

  task automatic testInvert();
    sendPair("R6 min", 1'b1, 16'h8000, 1'b0, 1'b0);
    sendPair("R6 zero", 1'b0, 16'h0000, 1'b0, 1'b0);
    sendPair("R6 mixed", 1'b1, 16'hA5C3, 1'b0, 1'b0);
  endtask

  task automatic testClamp();
    sendPair("R7 exact min", 1'b0, 16'h8000, 1'b1, 1'b1);
    sendPair("R7 invert min", 1'b1, 16'h8000, 1'b0, 1'b1);
    sendPair("R7 other untouched", 1'b0, 16'h8001, 1'b1, 1'b1);
  endtask

  task automatic testChannelAndHold();
    sendPair("R3 right", 1'b1, 16'h0ABC, 1'b1, 1'b0);
    // strobe on unselected left channel only
    @(negedge clk);
    chanSel = 1'b1; leftSample = 16'h5555; leftValid = 1'b1;
    @(negedge clk);
    leftValid = 1'b0;
    check("R3 ignored strobe", {31'd0, pairValid}, 32'd0);
    check("R3 ignored true", {16'd0, trueWord}, 32'h0ABC);
    check("R3 ignored comp", {16'd0, compWord}, 32'hF544);
    // settings change with no accepted sample
    exactMode = 1'b0; clampInput = 1'b1; chanSel = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 settings idle strobe", {31'd0, pairValid}, 32'd0);
    check("R8 R9 hold true", {16'd0, trueWord}, 32'h0ABC);
    check("R8 R9 hold comp", {16'd0, compWord}, 32'hF544);
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    chanSel = 1'b0; exactMode = 1'b1; clampInput = 1'b0;
    leftSample = 16'h0010; leftValid = 1'b1;
    @(negedge clk);
    check("R2 first", {16'd0, compWord}, 32'hFFF0);
    leftSample = 16'h0020; exactMode = 1'b0;
    @(negedge clk);
    leftValid = 1'b0;
    check("R2 back-to-back strobe", {31'd0, pairValid}, 32'd1);
    check("R8 mode per sample", {16'd0, compWord}, 32'hFFDF);
    @(negedge clk);
    check("R2 back-to-back end", {31'd0, pairValid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst = 1'b0;
    @(negedge clk);
    testExact();
    testInvert();
    testClamp();
    testChannelAndHold();
    testBackToBack();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    testReset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule